// File: doc/BRIEF.md
# IrDA SIR pulse encoder

This block turns the serial stream leaving a UART (`txd`, idle high) into short infrared pulses for an active-low LED enable. A zero bit produces one light pulse. A one bit, idle line and stop bit produce no light. It runs from a 3.6864 MHz system clock. An internal divider makes a 16x baud tick from a programmable divide value.

Each pulse lasts either a fixed 6 system clocks (about 1.63 µs at any baud rate) or 3 baud ticks, which is 3/16 of a bit.

There are two timing disciplines:
- **Framed mode.** The block finds the start bit and restarts its divider on that edge. It then times every bit of the character from its own tick, so pulse positions carry no jitter. The character length must be programmed.
- **Edge mode.** Each falling edge of `txd` fires a pulse at once. A low level that lasts for several bits repeats the pulse once per internal bit period.

Top module: `irsir_encoder`

## Requirements
- R1: After reset, and whenever `txd` stays high, `led_n` is 1 (LED off).
- R2: Only a zero bit on `txd` lights the LED, and `led_n` is active low. Each zero bit of start plus data yields exactly one low pulse. One bits, idle and the stop bit yield none.
- R3: With `cfg_wide_pulse`=0, every complete pulse holds `led_n` low for exactly 6 clock cycles.
- R4: With `cfg_wide_pulse`=1, every complete pulse holds `led_n` low for 3 baud ticks, which is 3*(`baud_div`+1) clock cycles.
- R5: The baud tick period is `baud_div`+1 clock cycles, and one bit lasts 16 ticks. For example, 23 gives 9600 bit/s and 1 gives 115200 bit/s.
- R6: With `cfg_edge_mode`=0 (framed), call E0 the clock edge at which `txd` is first seen low after being high while idle. The pulse for a zero bit b (b=0 is the start bit) begins at edge E0+(`baud_div`+1)*(16*b+8). It stays at that position whatever the divider phase was before E0.
- R7: `cfg_char_len` selects the data bits per framed character: 00=6, 01=7, 10=8, 11=9. Framing ends after the last data bit, and the block then waits for a new start edge.
- R8: With `cfg_edge_mode`=1, a falling edge of `txd` starts a pulse at that same edge. While `txd` stays low, a further pulse starts every 16*(`baud_div`+1) cycles after it.
- R9: While `tx_enable` is 0, `led_n` is 1 from the next cycle on, and no pulse starts. Dropping it abandons the character in progress, and a low `txd` level left over after re-enabling causes no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 3.6864 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Transmitter enable; 0 forces the LED off |
| txd | input | 1 | UART serial data, idle high |
| cfg_wide_pulse | input | 1 | 0: 6-clock pulse; 1: 3/16-bit pulse |
| cfg_edge_mode | input | 1 | 0: start-bit framed timing; 1: edge triggered |
| cfg_char_len | input | 2 | Framed data bits: 00=6, 01=7, 10=8, 11=9 |
| baud_div | input | 8 | Divider value; tick period is baud_div+1 clocks |
| led_n | output | 1 | LED enable, low lights the LED |

## Verification
Each result falls due at a fixed number of cycles after its stimulus:
- **Edge mode.** A pulse is visible in the cycle right after the edge that sees `txd` fall.
- **Framed mode.** Bit b's pulse appears (`baud_div`+1)*(16*b+8) edges after the start edge.
- **Pulse width.** `led_n` returns high 6 cycles, or 3*(`baud_div`+1) cycles, after the pulse begins.
- **Disable.** Dropping the enable darkens the LED after one edge.

The bench counts posedges from the first edge that sees the start bit. It samples `led_n` on the following negedge and changes `txd` only on negedges, every 16*(`baud_div`+1) cycles. Every sample is compared with a waveform computed from these offsets, so a pulse one cycle early, late, long or short is caught.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  localparam int TICKS_PER_BIT  = 16;
  localparam int BASE_CHAR_BITS = 6;

  typedef enum logic {FR_IDLE, FR_RUN} fr_state_t;

  function automatic int data_bits(input logic [1:0] code);
    return BASE_CHAR_BITS + int'(code);
  endfunction
endpackage

// File: rtl/irsir_baud_gen.sv
module irsir_baud_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] baud_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = en && !restart && (cnt_q == baud_div);

  always_comb begin
    cnt_d = cnt_q;
    if (!en || restart || tick) cnt_d = '0;
    else                        cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/irsir_framer.sv
module irsir_framer
  import irsir_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       txd,
  input  logic       edge_mode,
  input  logic [1:0] char_len,
  input  logic       tick,
  output logic       restart,
  output logic       launch
);
  localparam int TCNT_W = $clog2(TICKS_PER_BIT);
  localparam int BIDX_W = $clog2(BASE_CHAR_BITS + 4);
  localparam logic [TCNT_W-1:0] LAST_TICK = TCNT_W'(TICKS_PER_BIT - 1);
  localparam logic [TCNT_W-1:0] MID_TICK  = TCNT_W'(TICKS_PER_BIT / 2 - 1);

  fr_state_t         state_q, state_d;
  logic [TCNT_W-1:0] tcnt_q, tcnt_d;
  logic [BIDX_W-1:0] bidx_q, bidx_d;
  logic              txd_prev_q;
  logic              fall;
  logic [BIDX_W-1:0] last_bit;

  assign fall     = txd_prev_q && !txd;
  assign last_bit = BIDX_W'(data_bits(char_len));

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bidx_d  = bidx_q;
    restart = 1'b0;
    launch  = 1'b0;
    if (!en) begin
      state_d = FR_IDLE;
      tcnt_d  = '0;
      bidx_d  = '0;
    end else if (edge_mode) begin
      if (fall) begin
        restart = 1'b1;
        launch  = 1'b1;
        state_d = FR_RUN;
        tcnt_d  = '0;
      end else if (state_q == FR_RUN) begin
        if (txd) begin
          state_d = FR_IDLE;
        end else if (tick) begin
          if (tcnt_q == LAST_TICK) begin
            launch = 1'b1;
            tcnt_d = '0;
          end else begin
            tcnt_d = tcnt_q + TCNT_W'(1);
          end
        end
      end
    end else begin
      if (state_q == FR_IDLE) begin
        if (fall) begin
          restart = 1'b1;
          state_d = FR_RUN;
          tcnt_d  = '0;
          bidx_d  = '0;
        end
      end else if (tick) begin
        if (tcnt_q == MID_TICK && !txd) launch = 1'b1;
        if (tcnt_q == LAST_TICK) begin
          tcnt_d = '0;
          if (bidx_q == last_bit) state_d = FR_IDLE;
          else                    bidx_d  = bidx_q + BIDX_W'(1);
        end else begin
          tcnt_d = tcnt_q + TCNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= FR_IDLE;
      tcnt_q     <= '0;
      bidx_q     <= '0;
      txd_prev_q <= 1'b1;
    end else begin
      state_q    <= state_d;
      tcnt_q     <= tcnt_d;
      bidx_q     <= bidx_d;
      txd_prev_q <= txd;
    end
  end
endmodule

// File: rtl/irsir_pulse_gen.sv
module irsir_pulse_gen #(
  parameter int FIXED_PW_CLKS = 6,
  parameter int WIDE_PW_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic wide,
  input  logic tick,
  input  logic launch,
  output logic led_n
);
  localparam int PMAX   = (FIXED_PW_CLKS > WIDE_PW_TICKS) ? FIXED_PW_CLKS : WIDE_PW_TICKS;
  localparam int PCNT_W = $clog2(PMAX + 1);

  logic [PCNT_W-1:0] pcnt_q, pcnt_d;

  always_comb begin
    pcnt_d = pcnt_q;
    if (!en) begin
      pcnt_d = '0;
    end else if (launch) begin
      pcnt_d = wide ? PCNT_W'(WIDE_PW_TICKS) : PCNT_W'(FIXED_PW_CLKS);
    end else if (pcnt_q != '0 && (!wide || tick)) begin
      pcnt_d = pcnt_q - PCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assign led_n = (pcnt_q == '0);
endmodule

// File: rtl/irsir_encoder.sv
module irsir_encoder #(
  parameter int DIV_W         = 8,
  parameter int FIXED_PW_CLKS = 6,
  parameter int WIDE_PW_TICKS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_enable,
  input  logic             txd,
  input  logic             cfg_wide_pulse,
  input  logic             cfg_edge_mode,
  input  logic [1:0]       cfg_char_len,
  input  logic [DIV_W-1:0] baud_div,
  output logic             led_n
);
  logic [1:0] rst_pipe_q;
  logic       core_rst_n;
  logic       tick;
  logic       restart;
  logic       launch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  irsir_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(core_rst_n), .en(tx_enable), .restart(restart),
    .baud_div(baud_div), .tick(tick)
  );

  irsir_framer u_framer (
    .clk(clk), .rst_n(core_rst_n), .en(tx_enable), .txd(txd),
    .edge_mode(cfg_edge_mode), .char_len(cfg_char_len), .tick(tick),
    .restart(restart), .launch(launch)
  );

  irsir_pulse_gen #(.FIXED_PW_CLKS(FIXED_PW_CLKS), .WIDE_PW_TICKS(WIDE_PW_TICKS)) u_pulse (
    .clk(clk), .rst_n(core_rst_n), .en(tx_enable), .wide(cfg_wide_pulse),
    .tick(tick), .launch(launch), .led_n(led_n)
  );
endmodule

// File: rtl/irsir_encoder_chk.sv
module irsir_encoder_chk #(
  parameter int DIV_W         = 8,
  parameter int FIXED_PW_CLKS = 6,
  parameter int WIDE_PW_TICKS = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_enable,
  input logic             txd,
  input logic             cfg_wide_pulse,
  input logic [DIV_W-1:0] baud_div,
  input logic             led_n
);
  logic [15:0] run_q;
  logic [15:0] wide_len;

  assign wide_len = 16'(WIDE_PW_TICKS) * (16'(baud_div) + 16'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= led_n ? 16'd0 : run_q + 16'd1;
  end

  a_r2_pulse_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(led_n) |-> !$past(txd));

  a_r9_pulse_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(led_n) |-> $past(tx_enable));

  a_r9_disable_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> led_n);

  a_r3_fixed_not_longer: assert property (@(posedge clk) disable iff (!rst_n)
    (!led_n && !cfg_wide_pulse) |-> (run_q < 16'(FIXED_PW_CLKS)));

  a_r3_fixed_exact: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(led_n) && !cfg_wide_pulse && $past(tx_enable)) |-> (run_q == 16'(FIXED_PW_CLKS)));

  a_r4_wide_not_longer: assert property (@(posedge clk) disable iff (!rst_n)
    (!led_n && cfg_wide_pulse) |-> (run_q < wide_len));
endmodule

bind irsir_encoder irsir_encoder_chk #(
  .DIV_W(DIV_W), .FIXED_PW_CLKS(FIXED_PW_CLKS), .WIDE_PW_TICKS(WIDE_PW_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .txd(txd),
  .cfg_wide_pulse(cfg_wide_pulse), .baud_div(baud_div), .led_n(led_n)
);

// File: tb/tb_irsir_encoder.sv
module tb_irsir_encoder;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 190000;

  typedef struct packed {
    logic       edge_m;
    logic       wide;
    logic [1:0] len;
    logic [7:0] div;
    logic [8:0] data;
    logic [3:0] exp_pulses;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    {1'b0, 1'b0, 2'd2, 8'd1,  9'h0A5, 4'd5},
    {1'b0, 1'b1, 2'd2, 8'd2,  9'h00F, 4'd5},
    {1'b0, 1'b0, 2'd0, 8'd3,  9'h02A, 4'd4},
    {1'b0, 1'b1, 2'd1, 8'd1,  9'h07F, 4'd1},
    {1'b0, 1'b0, 2'd3, 8'd1,  9'h100, 4'd9},
    {1'b1, 1'b0, 2'd2, 8'd1,  9'h000, 4'd9},
    {1'b1, 1'b1, 2'd2, 8'd2,  9'h096, 4'd5},
    {1'b1, 1'b0, 2'd0, 8'd23, 9'h03F, 4'd1},
    {1'b0, 1'b0, 2'd2, 8'd23, 9'h055, 4'd5}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_enable;
  logic       txd;
  logic       cfg_wide_pulse;
  logic       cfg_edge_mode;
  logic [1:0] cfg_char_len;
  logic [7:0] baud_div;
  logic       led_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irsir_encoder dut (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .txd(txd),
    .cfg_wide_pulse(cfg_wide_pulse), .cfg_edge_mode(cfg_edge_mode),
    .cfg_char_len(cfg_char_len), .baud_div(baud_div), .led_n(led_n)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic bit model_low(input vec_t v, input int k);
    int unit  = int'(v.div) + 1;
    int blen  = 16 * unit;
    int off   = v.edge_m ? 0 : 8 * unit;
    int width = v.wide ? 3 * unit : 6;
    int nb    = 6 + int'(v.len);
    for (int b = 0; b <= nb; b++) begin
      bit val = (b == 0) ? 1'b0 : v.data[b-1];
      int s = b * blen + off;
      if (!val && k >= s && k < s + width) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic run_char(input vec_t v, input bit en_on, output int mism, output int pulses);
    int  blen, nb, total;
    bit  prev, exp_low;
    @(negedge clk);
    cfg_edge_mode  = v.edge_m;
    cfg_wide_pulse = v.wide;
    cfg_char_len   = v.len;
    baud_div       = v.div;
    tx_enable      = en_on;
    txd            = 1'b1;
    repeat (40) @(negedge clk);
    blen   = 16 * (int'(v.div) + 1);
    nb     = 6 + int'(v.len);
    total  = (nb + 2) * blen;
    mism   = 0;
    pulses = 0;
    prev   = 1'b1;
    txd    = 1'b0;
    for (int k = 0; k < total; k++) begin
      @(posedge clk);
      @(negedge clk);
      exp_low = en_on ? model_low(v, k) : 1'b0;
      if (led_n !== !exp_low) mism++;
      if (prev && led_n === 1'b0) pulses++;
      prev = led_n;
      if ((k + 1) % blen == 0) begin
        int idx = (k + 1) / blen;
        txd = (idx <= nb) ? v.data[idx-1] : 1'b1;
      end
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int mism, pulses, lows;
    rst_n = 1'b0; tx_enable = 1'b0; txd = 1'b1;
    cfg_wide_pulse = 1'b0; cfg_edge_mode = 1'b0; cfg_char_len = 2'd2; baud_div = 8'd23;
    repeat (3) @(negedge clk);
    check(led_n === 1'b1, "R1 reset state", int'(led_n), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    tx_enable = 1'b1;

    // R1: idle high line stays dark
    lows = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (led_n !== 1'b1) lows++;
    end
    check(lows == 0, "R1 idle line dark", lows, 0);

    // Table: R2 count, R3/R4 width, R5 tick, R6/R7 framed, R8 edge
    for (int i = 0; i < NVEC; i++) begin
      run_char(VECS[i], 1'b1, mism, pulses);
      if (VECS[i].edge_m)
        check(mism == 0, $sformatf("R8 R3 R4 R5 edge waveform vec%0d", i), mism, 0);
      else
        check(mism == 0, $sformatf("R6 R7 R3 R4 R5 framed waveform vec%0d", i), mism, 0);
      check(pulses == int'(VECS[i].exp_pulses), $sformatf("R2 pulse count vec%0d", i),
            pulses, int'(VECS[i].exp_pulses));
    end

    // R9: disabled transmitter sends nothing
    run_char({1'b0, 1'b0, 2'd2, 8'd1, 9'h000, 4'd0}, 1'b0, mism, pulses);
    check(pulses == 0, "R9 disabled no pulses", pulses, 0);

    // R9: disable during a framed start pulse, abandon the character
    @(negedge clk);
    cfg_edge_mode = 1'b0; cfg_wide_pulse = 1'b0; cfg_char_len = 2'd2; baud_div = 8'd1;
    tx_enable = 1'b1; txd = 1'b1;
    repeat (40) @(negedge clk);
    txd = 1'b0;
    lows = 0;
    for (int k = 0; k < 320; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 17) check(led_n === 1'b0, "R6 start pulse before disable", int'(led_n), 0);
      if (k == 19) check(led_n === 1'b1, "R9 disable cuts pulse", int'(led_n), 1);
      if (k > 19 && led_n !== 1'b1) lows++;
      if (k == 18) tx_enable = 1'b0;
      if (k == 22) tx_enable = 1'b1;
    end
    check(lows == 0, "R9 abandoned character stays dark", lows, 0);
    txd = 1'b1;
    repeat (20) @(negedge clk);

    // R8: edge mode fires in the cycle after the falling edge
    cfg_edge_mode = 1'b1;
    repeat (40) @(negedge clk);
    txd = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(led_n === 1'b0, "R8 edge pulse immediate", int'(led_n), 0);
    txd = 1'b1;
    repeat (40) @(negedge clk);
    check(led_n === 1'b1, "R1 dark after return high", int'(led_n), 1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule